// File: doc/BRIEF.md
# Serial Memory Slave Command Front End

This block is the serial side of a byte-wide memory slave on a four-wire SPI bus in mode 0. A system clock much faster than the serial clock oversamples SCK, chip select, hold and the serial input. The block frames each transaction on chip select and shifts in an 8-bit instruction, most significant bit first. It decodes the six instructions, collects a 16-bit address and data bytes, and shifts read data out on an enabled serial output that an external pad turns into a tri-state driver.

Writes leave the block as one-cycle strobes toward a separate write-control block: write-enable set, write-enable clear, status write and per-byte array write. The write-control block owns timing and protection. Reads fetch each byte from the array through a valid/ready request. A busy input from the write-control block limits what is accepted. Programming timing and protection are outside this block.

Top module: `serial_mem_frontend`

## Requirements
- R1: The instruction byte is decoded with bits 7..4 equal to zero and bit 3 ignored, using bits 2..0. The codes are 110 set write enable, 100 clear write enable, 101 read status, 001 write status, 011 read array and 010 write array. Set and clear each give a single one-cycle pulse on `wen_set_o` or `wen_clr_o` once the eighth bit is taken. At most one write-side strobe is high in any cycle.
- R2: While `cs_n_i` is high, SCK and SI have no effect, `so_oe_o` is 0, and the next falling edge of `cs_n_i` starts a new instruction.
- R3: Data moves most significant bit first. SI is taken on rising SCK. SO changes after falling SCK, and the first read bit appears after the falling edge that follows the last address bit.
- R4: A read-array transaction returns bytes from consecutive addresses. Address bits at and above `ADDR_W` are ignored. The address wraps from 2^ADDR_W-1 to 0.
- R5: Any instruction byte that is not one of the six codes causes no strobe. SO stays disabled until the next select.
- R6: While `busy_i` is high when the instruction byte completes, every instruction except read status gives no strobe and no output.
- R7: Read status sends `status_i` again for every byte while clocks continue. The value is captured at the falling edge that starts each byte.
- R8: Write status gives one `stat_wr_o` pulse with the first data byte on `wr_data_o`. Later bytes in the same select are ignored.
- R9: Write array gives one `wr_valid_o` pulse per data byte, with `wr_addr_o` and `wr_data_o`. Between bytes, only the low `PAGE_W` address bits count up, wrapping inside the page.
- R10: A change on `hold_n_i` acts only while SCK is low. Low pauses the transfer and high resumes it. While paused, SCK edges are ignored and `so_oe_o` is 0, and the transfer continues where it stopped.
- R11: A read fetch raises `rd_req_o` with `rd_addr_o`. Both stay unchanged until `rd_ready_i` is high, and `rd_data_i` is taken in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock pin |
| cs_n_i | input | 1 | Active-low chip select pin |
| hold_n_i | input | 1 | Active-low pause pin |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out, 0 when not enabled |
| so_oe_o | output | 1 | Output enable for the SO pad |
| busy_i | input | 1 | Internal write cycle in progress |
| status_i | input | 8 | Status byte to report |
| wen_set_o | output | 1 | Set write enable strobe |
| wen_clr_o | output | 1 | Clear write enable strobe |
| stat_wr_o | output | 1 | Status write strobe |
| wr_valid_o | output | 1 | Array byte write strobe |
| wr_addr_o | output | ADDR_W | Array write address |
| wr_data_o | output | 8 | Write data byte |
| rd_req_o | output | 1 | Read fetch request valid |
| rd_addr_o | output | ADDR_W | Read fetch address |
| rd_ready_i | input | 1 | Read fetch accept; data valid this cycle |
| rd_data_i | input | 8 | Read fetch data |

The write outputs have no back-pressure, because the SPI master cannot be stalled. The read fetch may wait on `rd_ready_i`, but it must finish before the next falling SCK edge, about half an SCK period later.

## Verification
Every serial pin goes through two synchronizer flops and an edge register. Each result therefore follows its SCK edge by three system clocks: an SO bit after a falling edge, a strobe after the eighth rising edge. The bench holds every SCK phase for eight system clocks and samples SO just before it raises SCK, so each bit has settled. Strobes are counted by a monitor, and the counts are compared only after the transaction ends and chip select has been high for a full bit time. Hold is checked with its level change placed in the low and in the high SCK phase.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
  typedef enum logic [2:0] {
    CMD_NONE, CMD_WEN_SET, CMD_WEN_CLR, CMD_STAT_RD, CMD_STAT_WR, CMD_ARR_RD, CMD_ARR_WR
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_WSTAT, ST_WARR, ST_RSTAT, ST_RARR, ST_SKIP
  } st_e;

  function automatic cmd_e decode_op(input logic [7:0] op);
    cmd_e c;
    c = CMD_NONE;
    if (op[7:4] == 4'd0) begin
      case (op[2:0])
        3'b110:  c = CMD_WEN_SET;
        3'b100:  c = CMD_WEN_CLR;
        3'b101:  c = CMD_STAT_RD;
        3'b001:  c = CMD_STAT_WR;
        3'b011:  c = CMD_ARR_RD;
        3'b010:  c = CMD_ARR_WR;
        default: c = CMD_NONE;
      endcase
    end
    return c;
  endfunction
endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  input  logic [N-1:0] init_i,
  output logic [N-1:0] sync_o
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{init_i[b]}};
      else        chain <= {chain[STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/spi_fe_hold.sv
module spi_fe_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic sck_s,
  input  logic hold_n_s,
  output logic held
);
  logic hold_n_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_n_q <= 1'b1;
      held     <= 1'b0;
    end else begin
      hold_n_q <= hold_n_s;
      if (!sel) held <= 1'b0;
      else if ((hold_n_s != hold_n_q) && !sck_s) held <= !hold_n_s;
    end
  end
endmodule

// File: rtl/spi_fe_tx.sv
module spi_fe_tx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         load,
  input  logic [W-1:0] load_byte,
  input  logic         shift,
  output logic         bit_o
);
  logic [W-1:0] sh;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh <= '0;
    else if (clear) sh <= '0;
    else if (load)  sh <= load_byte;
    else if (shift) sh <= {sh[W-2:0], 1'b0};
  end
  assign bit_o = sh[W-1];
endmodule

// File: rtl/serial_mem_frontend.sv
module serial_mem_frontend #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              cs_n_i,
  input  logic              hold_n_i,
  input  logic              si_i,
  output logic              so_o,
  output logic              so_oe_o,
  input  logic              busy_i,
  input  logic [7:0]        status_i,
  output logic              wen_set_o,
  output logic              wen_clr_o,
  output logic              stat_wr_o,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ready_i,
  input  logic [7:0]        rd_data_i
);
  import spi_fe_pkg::*;

  localparam int HI_W = ADDR_W - 8;

  logic [3:0] pins_s;
  logic       sck_s, cs_n_s, hold_n_s, si_s;
  logic       sck_d, sel, held, rise, fall, byte_done;
  logic [7:0] byte_val;
  logic [6:0] rx;
  logic [2:0] bitcnt;
  st_e        st;
  cmd_e       cmd;
  logic       is_rd, hi_done, tx_pend, tx_on, tx_bit;
  logic [HI_W-1:0]   hi_byte;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        fetch_buf;

  spi_fe_sync #(.N(4), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({sck_i, cs_n_i, hold_n_i, si_i}),
    .init_i(4'b0110),
    .sync_o(pins_s)
  );
  assign {sck_s, cs_n_s, hold_n_s, si_s} = pins_s;
  assign sel = !cs_n_s;

  spi_fe_hold u_hold (
    .clk(clk), .rst_n(rst_n), .sel(sel), .sck_s(sck_s),
    .hold_n_s(hold_n_s), .held(held)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= sck_s;
  end

  assign rise      = sel && (st != ST_IDLE) && !held && sck_s && !sck_d;
  assign fall      = sel && (st != ST_IDLE) && !held && !sck_s && sck_d;
  assign byte_val  = {rx, si_s};
  assign byte_done = rise && (bitcnt == 3'd7);
  assign cmd       = decode_op(byte_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; rx <= '0; bitcnt <= '0;
      is_rd <= 1'b0; hi_done <= 1'b0; hi_byte <= '0; addr <= '0;
      wen_set_o <= 1'b0; wen_clr_o <= 1'b0; stat_wr_o <= 1'b0; wr_valid_o <= 1'b0;
      wr_addr_o <= '0; wr_data_o <= '0;
      rd_req_o <= 1'b0; fetch_buf <= '0;
      tx_pend <= 1'b0; tx_on <= 1'b0;
    end else begin
      wen_set_o  <= 1'b0;
      wen_clr_o  <= 1'b0;
      stat_wr_o  <= 1'b0;
      wr_valid_o <= 1'b0;
      if (rd_req_o && rd_ready_i) begin
        rd_req_o  <= 1'b0;
        fetch_buf <= rd_data_i;
        addr      <= addr + 1'b1;
      end
      if (!sel) begin
        st <= ST_IDLE; tx_pend <= 1'b0; tx_on <= 1'b0; rd_req_o <= 1'b0;
      end else if (st == ST_IDLE) begin
        st <= ST_OPC; bitcnt <= '0;
      end else begin
        if (rise) begin
          rx     <= byte_val[6:0];
          bitcnt <= bitcnt + 1'b1;
        end
        if (byte_done) begin
          case (st)
            ST_OPC: begin
              if (busy_i && (cmd != CMD_STAT_RD)) st <= ST_SKIP;
              else begin
                case (cmd)
                  CMD_WEN_SET: begin wen_set_o <= 1'b1; st <= ST_SKIP; end
                  CMD_WEN_CLR: begin wen_clr_o <= 1'b1; st <= ST_SKIP; end
                  CMD_STAT_RD: begin st <= ST_RSTAT; tx_pend <= 1'b1; end
                  CMD_STAT_WR: st <= ST_WSTAT;
                  CMD_ARR_RD, CMD_ARR_WR: begin
                    st <= ST_ADDR; is_rd <= (cmd == CMD_ARR_RD); hi_done <= 1'b0;
                  end
                  default: st <= ST_SKIP;
                endcase
              end
            end
            ST_ADDR: begin
              if (!hi_done) begin
                hi_byte <= byte_val[HI_W-1:0];
                hi_done <= 1'b1;
              end else begin
                addr <= {hi_byte, byte_val};
                if (is_rd) begin
                  st <= ST_RARR; rd_req_o <= 1'b1; tx_pend <= 1'b1;
                end else st <= ST_WARR;
              end
            end
            ST_WSTAT: begin
              stat_wr_o <= 1'b1; wr_data_o <= byte_val; st <= ST_SKIP;
            end
            ST_WARR: begin
              wr_valid_o <= 1'b1; wr_data_o <= byte_val; wr_addr_o <= addr;
              addr[PAGE_W-1:0] <= addr[PAGE_W-1:0] + 1'b1;
            end
            ST_RARR: begin rd_req_o <= 1'b1; tx_pend <= 1'b1; end
            ST_RSTAT: tx_pend <= 1'b1;
            default: ;
          endcase
        end
        if (fall && tx_pend) begin
          tx_pend <= 1'b0;
          tx_on   <= 1'b1;
        end
      end
    end
  end

  spi_fe_tx #(.W(8)) u_tx (
    .clk(clk), .rst_n(rst_n), .clear(!sel),
    .load(fall && tx_pend),
    .load_byte((st == ST_RSTAT) ? status_i : fetch_buf),
    .shift(fall && tx_on),
    .bit_o(tx_bit)
  );

  assign rd_addr_o = addr;
  assign so_oe_o   = sel && !held && tx_on && ((st == ST_RSTAT) || (st == ST_RARR));
  assign so_o      = so_oe_o && tx_bit;
endmodule

// File: rtl/serial_mem_frontend_chk.sv
module serial_mem_frontend_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel,
  input logic              held,
  input logic              so_oe_o,
  input logic              busy_i,
  input logic              wen_set_o,
  input logic              wen_clr_o,
  input logic              stat_wr_o,
  input logic              wr_valid_o,
  input logic              rd_req_o,
  input logic              rd_ready_i,
  input logic [ADDR_W-1:0] rd_addr_o
);
  assert_deselect_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !so_oe_o);
  assert_hold_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> !so_oe_o);
  assert_strobe_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wen_set_o, wen_clr_o, stat_wr_o, wr_valid_o}));
  assert_wen_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wen_set_o |=> !wen_set_o);
  assert_busy_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wen_set_o || wen_clr_o) |-> !$past(busy_i));
  assert_req_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_ready_i) |=> (rd_req_o && $stable(rd_addr_o)));
endmodule

bind serial_mem_frontend serial_mem_frontend_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .held(held), .so_oe_o(so_oe_o),
  .busy_i(busy_i), .wen_set_o(wen_set_o), .wen_clr_o(wen_clr_o),
  .stat_wr_o(stat_wr_o), .wr_valid_o(wr_valid_o), .rd_req_o(rd_req_o),
  .rd_ready_i(rd_ready_i), .rd_addr_o(rd_addr_o)
);

// File: tb/serial_mem_frontend_tb_top.sv
module serial_mem_frontend_tb_top;
  localparam int AW   = 13;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, hold_n = 1'b1, si = 1'b0;
  logic busy = 1'b0, rd_ready = 1'b0;
  logic [7:0] status = 8'h00, rd_data = 8'h00;
  logic so, so_oe, wen_set, wen_clr, stat_wr, wr_valid, rd_req;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [7:0] wr_data;

  int checks = 0, errors = 0;
  int n_set = 0, n_clr = 0, n_stat = 0, n_wr = 0;
  logic [AW-1:0] wlog_addr [0:7];
  logic [7:0]    wlog_data [0:7];
  logic [7:0]    last_stat;
  bit done = 1'b0;

  always #4 clk = ~clk;

  serial_mem_frontend #(.ADDR_W(AW), .PAGE_W(5)) dut_i (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .cs_n_i(cs_n), .hold_n_i(hold_n), .si_i(si),
    .so_o(so), .so_oe_o(so_oe), .busy_i(busy), .status_i(status),
    .wen_set_o(wen_set), .wen_clr_o(wen_clr), .stat_wr_o(stat_wr),
    .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_ready_i(rd_ready), .rd_data_i(rd_data)
  );

  function automatic logic [7:0] memf(input logic [AW-1:0] a);
    return a[7:0] ^ {a[12:8], 3'b101};
  endfunction

  // strobe monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (wen_set) n_set++;
    if (wen_clr) n_clr++;
    if (stat_wr) begin n_stat++; last_stat = wr_data; end
    if (wr_valid) begin
      if (n_wr < 8) begin wlog_addr[n_wr] = wr_addr; wlog_data[n_wr] = wr_data; end
      n_wr++;
    end
  end

  // array responder: accepts a fetch after two waiting cycles
  initial begin
    int wait_c;
    wait_c = 0;
    forever begin
      @(negedge clk);
      rd_ready = 1'b0;
      if (rd_req) begin
        wait_c++;
        if (wait_c >= 3) begin rd_ready = 1'b1; rd_data = memf(rd_addr); wait_c = 0; end
      end else wait_c = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sck_bit(input logic b, output logic o, output logic oe);
    si = b;
    wait_clk(HALF);
    o = so; oe = so_oe;
    sck = 1'b1;
    wait_clk(HALF);
    sck = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] b, output logic [7:0] r, output logic oe_all,
                      output logic oe_any);
    logic o, oe;
    oe_all = 1'b1; oe_any = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      sck_bit(b[i], o, oe);
      r[i] = o; oe_all &= oe; oe_any |= oe;
    end
  endtask

  task automatic sel_on;
    cs_n = 1'b0; wait_clk(HALF);
  endtask

  task automatic sel_off;
    wait_clk(HALF); cs_n = 1'b1; wait_clk(2*HALF);
  endtask

  task automatic t_reset;
    chk(so_oe == 1'b0 && so == 1'b0, "R2 reset output", so_oe, 0);
    chk(!wen_set && !wen_clr && !stat_wr && !wr_valid && !rd_req, "R1 reset strobes", 1, 0);
  endtask

  task automatic t_wen;
    logic [7:0] r; logic a, y;
    int s0, c0;
    s0 = n_set; c0 = n_clr;
    sel_on; xfer(8'h06, r, a, y); sel_off;
    chk(n_set == s0 + 1, "R1 set write enable", n_set - s0, 1);
    sel_on; xfer(8'h0E, r, a, y); xfer(8'h55, r, a, y); sel_off;
    chk(n_set == s0 + 2, "R1 don't-care bit 3", n_set - s0, 2);
    sel_on; xfer(8'h04, r, a, y); sel_off;
    chk(n_clr == c0 + 1 && n_set == s0 + 2, "R1 clear write enable", n_clr - c0, 1);
  endtask

  task automatic t_invalid;
    logic [7:0] r; logic a, y;
    int tot;
    tot = n_set + n_clr + n_stat + n_wr;
    sel_on; xfer(8'h16, r, a, y); xfer(8'h06, r, a, y); xfer(8'hFF, r, a, y); sel_off;
    chk(n_set + n_clr + n_stat + n_wr == tot && !y, "R5 upper bits set", y, 0);
    sel_on; xfer(8'h07, r, a, y); xfer(8'h00, r, a, y); sel_off;
    chk(n_set + n_clr + n_stat + n_wr == tot && !y, "R5 code 111", y, 0);
  endtask

  task automatic read_seq(input logic [15:0] ad, input int nb, input string req);
    logic [7:0] r; logic a, y;
    logic [AW-1:0] exp_a;
    exp_a = ad[AW-1:0];
    sel_on;
    xfer(8'h03, r, a, y); xfer(ad[15:8], r, a, y); xfer(ad[7:0], r, a, y);
    for (int k = 0; k < nb; k++) begin
      xfer(8'hA5, r, a, y);
      chk(r == memf(exp_a) && a, req, r, memf(exp_a));
      exp_a = exp_a + 1'b1;
    end
    sel_off;
  endtask

  task automatic t_read;
    read_seq(16'hF234, 3, "R4 R3 R11 read upper bits ignored");
    read_seq(16'h1FFE, 3, "R4 read wrap at top");
  endtask

  task automatic t_write;
    logic [7:0] r; logic a, y;
    int w0;
    w0 = n_wr;
    sel_on;
    xfer(8'h02, r, a, y); xfer(8'h00, r, a, y); xfer(8'h3E, r, a, y);
    xfer(8'h11, r, a, y); xfer(8'h22, r, a, y); xfer(8'h33, r, a, y);
    sel_off;
    chk(n_wr - w0 == 3 && !y, "R9 write byte count", n_wr - w0, 3);
    chk(wlog_addr[w0] == 13'h3E && wlog_data[w0] == 8'h11, "R9 first byte", wlog_addr[w0], 13'h3E);
    chk(wlog_addr[w0+1] == 13'h3F && wlog_data[w0+1] == 8'h22, "R9 second byte", wlog_addr[w0+1], 13'h3F);
    chk(wlog_addr[w0+2] == 13'h20 && wlog_data[w0+2] == 8'h33, "R9 page wrap", wlog_addr[w0+2], 13'h20);
  endtask

  task automatic t_wstat;
    logic [7:0] r; logic a, y;
    int s0;
    s0 = n_stat;
    sel_on; xfer(8'h01, r, a, y); xfer(8'h8C, r, a, y); xfer(8'h73, r, a, y); sel_off;
    chk(n_stat == s0 + 1 && last_stat == 8'h8C, "R8 status write", last_stat, 8'h8C);
  endtask

  task automatic t_rstat;
    logic [7:0] r; logic a, y;
    status = 8'h02;
    sel_on; xfer(8'h05, r, a, y);
    wait_clk(4); status = 8'h83;
    xfer(8'h00, r, a, y);
    chk(r == 8'h02 && a, "R7 first status byte", r, 8'h02);
    xfer(8'h00, r, a, y);
    chk(r == 8'h83 && a, "R7 repeated status byte", r, 8'h83);
    sel_off;
  endtask

  task automatic t_busy;
    logic [7:0] r; logic a, y;
    int s0, w0;
    s0 = n_set; w0 = n_wr;
    busy = 1'b1; status = 8'hFF;
    sel_on; xfer(8'h06, r, a, y); sel_off;
    chk(n_set == s0, "R6 set ignored while busy", n_set - s0, 0);
    sel_on; xfer(8'h02, r, a, y); xfer(8'h00, r, a, y); xfer(8'h10, r, a, y); xfer(8'h44, r, a, y); sel_off;
    chk(n_wr == w0, "R6 write ignored while busy", n_wr - w0, 0);
    sel_on; xfer(8'h03, r, a, y); xfer(8'h00, r, a, y); xfer(8'h10, r, a, y); xfer(8'h00, r, a, y); sel_off;
    chk(!y, "R6 read ignored while busy", y, 0);
    sel_on; xfer(8'h05, r, a, y); xfer(8'h00, r, a, y); sel_off;
    chk(r == 8'hFF && a, "R6 status read while busy", r, 8'hFF);
    busy = 1'b0;
  endtask

  task automatic t_hold;
    logic [7:0] r; logic a, y, o, oe;
    logic [AW-1:0] ad;
    ad = 13'h0155;
    sel_on;
    xfer(8'h03, r, a, y); xfer(8'h01, r, a, y); xfer(8'h55, r, a, y);
    for (int i = 7; i >= 4; i--) begin sck_bit(1'b0, o, oe); r[i] = o; end
    hold_n = 1'b0; wait_clk(HALF);
    chk(so_oe == 1'b0, "R10 output off while paused", so_oe, 0);
    for (int k = 0; k < 3; k++) sck_bit(1'b1, o, oe);
    hold_n = 1'b1; wait_clk(HALF);
    for (int i = 3; i >= 0; i--) begin sck_bit(1'b0, o, oe); r[i] = o; end
    chk(r == memf(ad), "R10 byte continues after pause", r, memf(ad));
    // pause level change while SCK high has no effect
    si = 1'b0; wait_clk(HALF); r[7] = so; sck = 1'b1; wait_clk(HALF/2);
    hold_n = 1'b0; wait_clk(HALF/2); sck = 1'b0;
    for (int i = 6; i >= 0; i--) begin sck_bit(1'b0, o, oe); r[i] = o; end
    chk(r == memf(ad + 1'b1) && so_oe, "R10 change with SCK high ignored", r, memf(ad + 1'b1));
    hold_n = 1'b1;
    sel_off;
  endtask

  task automatic t_deselect;
    logic o, oe;
    int tot;
    tot = n_set + n_clr + n_stat + n_wr;
    for (int k = 0; k < 16; k++) begin
      sck_bit(k[0] ? 1'b0 : 1'b1, o, oe);
      chk(!oe, "R2 output off while deselected", oe, 0);
    end
    chk(n_set + n_clr + n_stat + n_wr == tot, "R2 no strobe while deselected",
        n_set + n_clr + n_stat + n_wr - tot, 0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset;
    t_wen;
    t_invalid;
    t_read;
    t_write;
    t_wstat;
    t_rstat;
    t_busy;
    t_hold;
    t_deselect;
    finish_run;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    finish_run;
  end
endmodule